// File: doc/BRIEF.md
# Software-Raised Interrupt Status Controller

This block holds a 32-bit word of pending interrupt causes. Software can set arbitrary bits by writing to a raise port and clear them by writing to an acknowledge port. Internal engines, such as a compute unit or a transfer engine, can also post causes through a per-bit set-request input. A read port returns the word at the status offset.

The pending word drives one of two signalling styles, chosen by a mode input. In level mode, an interrupt line stays high while any cause is pending. In message mode, a one-cycle pulse marks each new raise event and the level line stays low. In both modes a cause stays pending until software acknowledges it.

Register offsets are parameters. The defaults are: status read at 0x24, raise write at 0x60 and acknowledge write at 0x64.

Top module: `irq_status_ctrl`

## Requirements
- R1: While rst_ni is low, the status word is 0 and both line_irq_o and msg_pulse_o are low.
- R2: A write at offset 0x60 ORs wr_data_i into the status word at that clock edge.
- R3: A write at offset 0x64 clears each status bit whose wr_data_i bit is 1 and leaves the other bits unchanged.
- R4: rd_data_o returns the status word when rd_addr_i is 0x24 and returns 0 for any other address.
- R5: A write at any offset other than 0x60 or 0x64 leaves the status word unchanged.
- R6: Each 1 bit of src_set_i at a clock edge sets the matching status bit.
- R7: If a set (from a raise write or src_set_i) and an acknowledge clear hit the same bit at one edge, the bit ends up set.
- R8: With msg_mode_i low, line_irq_o is high exactly while the status word is nonzero, so it stays high until every pending bit is acknowledged.
- R9: With msg_mode_i high, line_irq_o is low, and pending bits stay set until they are cleared through offset 0x64.
- R10: With msg_mode_i high, msg_pulse_o is high for the one cycle after each edge at which a nonzero set is applied. It stays low after a raise write of 0 and whenever msg_mode_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write offset |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 8 | Read offset |
| rd_data_o | output | 32 | Read data (status word or 0) |
| src_set_i | input | 32 | Per-bit set requests from internal engines |
| msg_mode_i | input | 1 | 0 selects level signalling, 1 selects message pulses |
| line_irq_o | output | 1 | Level interrupt line |
| msg_pulse_o | output | 1 | One-cycle message interrupt pulse |

## Verification
The bench drives an acknowledge and a source set on the same bit at the same edge. A design that lets the clear win would drop a cause and report a zero bit. Writes to a non-interrupt offset carry all-ones data, so any decode that ignores the offset would corrupt the word. In message mode, the bench checks that the pulse lasts one cycle, that a zero-valued raise produces no pulse, and that causes stay pending without an acknowledge. A design that cleared on pulse, or held the pulse high as a level, would show a wrong status or a stuck pulse. A raise in level mode must not produce a pulse, and the level line must stay high through a partial acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,
    WR_RAISE = 2'd1,
    WR_ACK   = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned OFF_RAISE = 'h60,
  parameter int unsigned OFF_ACK   = 'h64
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output irq_pkg::wr_kind_e kind_o
);
  localparam logic [ADDR_W-1:0] RaiseAddr = ADDR_W'(OFF_RAISE);
  localparam logic [ADDR_W-1:0] AckAddr   = ADDR_W'(OFF_ACK);

  always_comb begin
    kind_o = irq_pkg::WR_NONE;
    if (wr_en_i) begin
      if (wr_addr_i == RaiseAddr)    kind_o = irq_pkg::WR_RAISE;
      else if (wr_addr_i == AckAddr) kind_o = irq_pkg::WR_ACK;
    end
  end

  always_comb begin
    if (!wr_en_i) assert (kind_o == irq_pkg::WR_NONE) else $error("p_idle_no_kind_r5");
  end
endmodule

// File: rtl/irq_status_word.sv
module irq_status_word #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  irq_pkg::wr_kind_e kind_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] src_set_i,
  output logic [DATA_W-1:0] status_o,
  output logic              set_event_o
);
  logic [DATA_W-1:0] set_vec, clr_vec, status_q;
  logic              past_valid_q;

  assign set_vec = (kind_i == irq_pkg::WR_RAISE ? wr_data_i : '0) | src_set_i;
  assign clr_vec = (kind_i == irq_pkg::WR_ACK) ? wr_data_i : '0;

  // set applied after clear so that set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_valid_q <= 1'b0;
    else         past_valid_q <= 1'b1;
  end

  assign status_o    = status_q;
  assign set_event_o = |set_vec;

  p_set_sticks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid_q |-> ((status_q & $past(set_vec)) == $past(set_vec)));
  p_rise_needs_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid_q |-> ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0));
  p_fall_needs_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid_q |-> ((~status_q & $past(status_q) & ~$past(clr_vec)) == '0));
endmodule

// File: rtl/irq_signal_out.sv
module irq_signal_out #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_mode_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic              set_event_i,
  output logic              line_irq_o,
  output logic              msg_pulse_o
);
  logic pulse_q, past_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q      <= 1'b0;
      past_valid_q <= 1'b0;
    end else begin
      pulse_q      <= msg_mode_i & set_event_i;
      past_valid_q <= 1'b1;
    end
  end

  assign line_irq_o  = ~msg_mode_i & (|status_i);
  assign msg_pulse_o = pulse_q;

  p_pulse_after_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid_q && msg_pulse_o |-> $past(set_event_i) && $past(msg_mode_i));
  p_pulse_has_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_pulse_o |-> (status_i != '0) || $past(msg_mode_i));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned OFF_STATUS = 'h24,
  parameter int unsigned OFF_RAISE  = 'h60,
  parameter int unsigned OFF_ACK    = 'h64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [DATA_W-1:0] src_set_i,
  input  logic              msg_mode_i,
  output logic              line_irq_o,
  output logic              msg_pulse_o
);
  localparam logic [ADDR_W-1:0] StatusAddr = ADDR_W'(OFF_STATUS);

  irq_pkg::wr_kind_e kind;
  logic [DATA_W-1:0] status;
  logic              set_event;

  irq_wr_decode #(.ADDR_W(ADDR_W), .OFF_RAISE(OFF_RAISE), .OFF_ACK(OFF_ACK)) i_decode (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .kind_o   (kind)
  );

  irq_status_word #(.DATA_W(DATA_W)) i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kind_i     (kind),
    .wr_data_i  (wr_data_i),
    .src_set_i  (src_set_i),
    .status_o   (status),
    .set_event_o(set_event)
  );

  irq_signal_out #(.DATA_W(DATA_W)) i_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .msg_mode_i (msg_mode_i),
    .status_i   (status),
    .set_event_i(set_event),
    .line_irq_o (line_irq_o),
    .msg_pulse_o(msg_pulse_o)
  );

  assign rd_data_o = (rd_addr_i == StatusAddr) ? status : '0;

  p_msg_line_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_mode_i |-> !line_irq_o);
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !line_irq_o && !msg_pulse_o);
endmodule

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [7:0]  rd_addr_i = 8'h24;
  logic [31:0] rd_data_o;
  logic [31:0] src_set_i = '0;
  logic        msg_mode_i = 1'b0;
  logic        line_irq_o, msg_pulse_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_status_ctrl i_irq_status_ctrl (.*);

  typedef struct packed {
    logic        wen;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] src;
    logic        mode;
    logic [31:0] exp_st;
    logic        exp_line;
    logic        exp_pulse;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h60, 32'h0000_0011, 32'h0,         1'b0, 32'h0000_0011, 1'b1, 1'b0}, // R2 R8
    '{1'b1, 8'h60, 32'h0000_0100, 32'h0,         1'b0, 32'h0000_0111, 1'b1, 1'b0}, // R2
    '{1'b1, 8'h64, 32'h0000_0001, 32'h0,         1'b0, 32'h0000_0110, 1'b1, 1'b0}, // R3 R8
    '{1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0,         1'b0, 32'h0000_0110, 1'b1, 1'b0}, // R5
    '{1'b0, 8'h60, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 32'h8000_0110, 1'b1, 1'b0}, // R6, R5 no strobe
    '{1'b1, 8'h64, 32'h0000_0010, 32'h0000_0010, 1'b0, 32'h8000_0110, 1'b1, 1'b0}, // R7
    '{1'b1, 8'h64, 32'hFFFF_FFFF, 32'h0,         1'b0, 32'h0,         1'b0, 1'b0}, // R3 R8
    '{1'b1, 8'h60, 32'h0000_0004, 32'h0,         1'b1, 32'h0000_0004, 1'b0, 1'b1}, // R9 R10
    '{1'b0, 8'h00, 32'h0,         32'h0,         1'b1, 32'h0000_0004, 1'b0, 1'b0}, // R9 R10
    '{1'b1, 8'h60, 32'h0,         32'h0,         1'b1, 32'h0000_0004, 1'b0, 1'b0}, // R10 zero raise
    '{1'b0, 8'h00, 32'h0,         32'h0000_0002, 1'b1, 32'h0000_0006, 1'b0, 1'b1}, // R6 R10
    '{1'b1, 8'h64, 32'h0000_0006, 32'h0,         1'b1, 32'h0,         1'b0, 1'b0}, // R9
    '{1'b1, 8'h60, 32'h0000_0008, 32'h0,         1'b0, 32'h0000_0008, 1'b1, 1'b0}, // R10 legacy
    '{1'b1, 8'h64, 32'h0000_0008, 32'h0,         1'b0, 32'h0,         1'b0, 1'b0}  // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    // R1 reset state
    check("R1 status", rd_data_o, 32'h0);
    check("R1 line", {31'b0, line_irq_o}, 32'h0);
    check("R1 pulse", {31'b0, msg_pulse_o}, 32'h0);
    step();
    rst_ni = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      wr_en_i    = VECS[i].wen;
      wr_addr_i  = VECS[i].addr;
      wr_data_i  = VECS[i].data;
      src_set_i  = VECS[i].src;
      msg_mode_i = VECS[i].mode;
      step();
      wr_en_i   = 1'b0;
      src_set_i = '0;
      check($sformatf("R4/R2/R3/R5/R6/R7 vec%0d status", i), rd_data_o, VECS[i].exp_st);
      check($sformatf("R8/R9 vec%0d line", i), {31'b0, line_irq_o}, {31'b0, VECS[i].exp_line});
      check($sformatf("R10 vec%0d pulse", i), {31'b0, msg_pulse_o}, {31'b0, VECS[i].exp_pulse});
    end

    // R4: other read address returns 0 while status nonzero
    msg_mode_i = 1'b0;
    wr_en_i = 1'b1; wr_addr_i = 8'h60; wr_data_i = 32'hA5A5_0000;
    step();
    wr_en_i = 1'b0;
    check("R4 status read", rd_data_o, 32'hA5A5_0000);
    rd_addr_i = 8'h60;
    #1 check("R4 other read", rd_data_o, 32'h0);
    rd_addr_i = 8'h24;

    // R10: back-to-back raises in message mode give a pulse each cycle, then drop
    msg_mode_i = 1'b1;
    src_set_i = 32'h1;
    step();
    check("R10 first pulse", {31'b0, msg_pulse_o}, 32'h1);
    src_set_i = 32'h2;
    step();
    src_set_i = '0;
    check("R10 second pulse", {31'b0, msg_pulse_o}, 32'h1);
    step();
    check("R10 pulse drop", {31'b0, msg_pulse_o}, 32'h0);
    check("R9 pending kept", rd_data_o, 32'hA5A5_0003);

    // R1: asynchronous reset mid-run clears everything
    msg_mode_i = 1'b0;
    #1 rst_ni = 1'b0;
    #1 check("R1 async clear", rd_data_o, 32'h0);
    check("R1 line cleared", {31'b0, line_irq_o}, 32'h0);
    step();
    rst_ni = 1'b1;
    step();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule